// File: doc/BRIEF.md
# Banked High-Memory Address Mapper

This block translates every access of an 8-bit CPU with a 64 KB address space into a physical memory target. The mapping works at 256-byte page granularity. It is purely combinational. Each cycle it takes the CPU address, the read/write direction and four mode flags, and returns the following:

- a 3-bit target code naming the physical store,
- an I/O indication,
- a write-inhibit line,
- the unchanged 16-bit offset.

The four mode flags are high-RAM read enable, high-RAM write enable, second-bank select and alternate zero page. The soft-switch logic that holds these flags lives outside this block.

Two parts of the space are redirected. The zero page and the stack page can be moved to auxiliary RAM. The top 12 KB can be served from ROM or from banked RAM. Its lower 4 KB has two banks, each in main or auxiliary RAM. Its upper 8 KB has a single copy in main or auxiliary RAM. The page window just above the I/O page is protected against writes.

Top module: `bankMapper`

## Requirements
- R1: For addresses $0000–$01FF, reads and writes give target 2 (auxiliary) when altZp is 1, and target 1 (main) otherwise. wrInhibit stays 0.
- R2: For addresses $0200–$BFFF, the target is always 1 (main) and wrInhibit is 0, whatever the mode flags are.
- R3: For addresses $C000–$C0FF, ioSel is 1, memSel is 0 and wrInhibit is 0. Outside that page, ioSel is 0.
- R4: For addresses $C100–$CFFF, reads give target 0 (ROM). Writes raise wrInhibit whatever the flags are.
- R5: For reads of $D000–$FFFF with hiRdEn at 0, the target is 0 (ROM).
- R6: For reads of $D000–$DFFF with hiRdEn at 1, the target comes from bankTwo and altZp: 3 = first bank main, 4 = second bank main, 5 = first bank auxiliary, 6 = second bank auxiliary.
- R7: For reads of $E000–$FFFF with hiRdEn at 1, the target is 1 (main), or 2 (auxiliary) when altZp is 1. bankTwo has no effect on this region.
- R8: For writes to $D000–$FFFF with hiWrEn at 0, wrInhibit is 1. The target follows the read mapping of R5–R7.
- R9: For writes to $D000–$FFFF with hiWrEn at 1, wrInhibit is 0 and the target is the RAM variant of R6/R7, whatever hiRdEn is.
- R10: physAddr always equals cpuAddr.
- R11: wrInhibit is 0 whenever cpuWrite is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| cpuAddr | input | 16 | CPU byte address |
| cpuWrite | input | 1 | 1 = write access, 0 = read access |
| hiRdEn | input | 1 | High RAM read enable |
| hiWrEn | input | 1 | High RAM write enable |
| bankTwo | input | 1 | Selects the second bank in $D000–$DFFF |
| altZp | input | 1 | Alternate zero page / auxiliary select |
| memSel | output | 3 | Target code (0 ROM, 1 main, 2 aux, 3–6 bank variants) |
| ioSel | output | 1 | Access falls in the I/O page |
| wrInhibit | output | 1 | Current write must be dropped |
| physAddr | output | 16 | Offset within the selected target |

## Verification
The bench builds the mapper with its default parameters. These are a 16-bit address, 8-bit page numbers, and region boundaries at pages $02, $C0, $C1, $D0 and $E0.

The sweep covers the pages on both sides of every boundary. At each of these pages it applies all 32 combinations of direction and mode flags. This reaches the cases where a single page of error would show:

- the edges of the stack page,
- the I/O page against the protected window,
- the split between the banked and unbanked high regions.

// File: rtl/bank_map_pkg.sv
package bank_map_pkg;

  typedef enum logic [2:0] {
    TGT_ROM     = 3'd0,
    TGT_MAIN    = 3'd1,
    TGT_AUX     = 3'd2,
    TGT_B1_MAIN = 3'd3,
    TGT_B2_MAIN = 3'd4,
    TGT_B1_AUX  = 3'd5,
    TGT_B2_AUX  = 3'd6
  } target_e;

  // region strobes passed from control to datapath
  typedef struct packed {
    logic zeroStack;   // remappable low pages
    logic plainLow;    // straight-through main RAM
    logic ioPage;      // I/O page
    logic romWin;      // write-protected window
    logic bankLow;     // banked lower high region
    logic bankHigh;    // unbanked upper high region
    logic ramAccess;   // high region served from RAM
    logic blockWrite;  // drop this write
  } map_strobe_t;

endpackage

// File: rtl/mapCtrl.sv
module mapCtrl
  import bank_map_pkg::*;
#(
  parameter int PAGE_W        = 8,
  parameter int STACK_END     = 8'h01,
  parameter int IO_PAGE       = 8'hC0,
  parameter int ROMWIN_END    = 8'hCF,
  parameter int BANK_START    = 8'hD0,
  parameter int BANK_SPLIT    = 8'hE0
) (
  input  logic [PAGE_W-1:0] page,
  input  logic              cpuWrite,
  input  logic              hiRdEn,
  input  logic              hiWrEn,
  output map_strobe_t       strobes
);

  localparam logic [PAGE_W-1:0] StackEndP = PAGE_W'(STACK_END);
  localparam logic [PAGE_W-1:0] IoP       = PAGE_W'(IO_PAGE);
  localparam logic [PAGE_W-1:0] RomEndP   = PAGE_W'(ROMWIN_END);
  localparam logic [PAGE_W-1:0] BankP     = PAGE_W'(BANK_START);
  localparam logic [PAGE_W-1:0] SplitP    = PAGE_W'(BANK_SPLIT);

  logic inHigh;

  always_comb begin
    strobes           = '0;
    strobes.zeroStack = (page <= StackEndP);
    strobes.plainLow  = (page > StackEndP) && (page < IoP);
    strobes.ioPage    = (page == IoP);
    strobes.romWin    = (page > IoP) && (page <= RomEndP);
    strobes.bankLow   = (page >= BankP) && (page < SplitP);
    strobes.bankHigh  = (page >= SplitP);
    inHigh            = strobes.bankLow || strobes.bankHigh;
    strobes.ramAccess = hiRdEn || (cpuWrite && hiWrEn);
    strobes.blockWrite = cpuWrite && (strobes.romWin || (inHigh && !hiWrEn));
  end

  always_comb begin
    if (!$isunknown({page, cpuWrite, hiRdEn, hiWrEn})) begin
      p_region_onehot_r2: assert ($onehot({strobes.zeroStack, strobes.plainLow,
                                           strobes.ioPage, strobes.romWin,
                                           strobes.bankLow, strobes.bankHigh}))
        else $error("region strobes not one-hot");
      p_block_needs_write_r11: assert (!strobes.blockWrite || cpuWrite)
        else $error("write block raised on a read");
    end
  end

endmodule

// File: rtl/mapDatapath.sv
module mapDatapath
  import bank_map_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic [ADDR_W-1:0] cpuAddr,
  input  map_strobe_t       strobes,
  input  logic              cpuWrite,
  input  logic              hiRdEn,
  input  logic              hiWrEn,
  input  logic              bankTwo,
  input  logic              altZp,
  output logic [2:0]        memSel,
  output logic              ioSel,
  output logic              wrInhibit,
  output logic [ADDR_W-1:0] physAddr
);

  target_e tgt;
  target_e plainRam;
  target_e bankedRam;

  always_comb begin
    plainRam  = altZp ? TGT_AUX : TGT_MAIN;
    case ({altZp, bankTwo})
      2'b00:   bankedRam = TGT_B1_MAIN;
      2'b01:   bankedRam = TGT_B2_MAIN;
      2'b10:   bankedRam = TGT_B1_AUX;
      default: bankedRam = TGT_B2_AUX;
    endcase

    tgt = TGT_ROM;
    if (strobes.zeroStack)     tgt = plainRam;
    else if (strobes.plainLow) tgt = TGT_MAIN;
    else if (strobes.bankLow)  tgt = strobes.ramAccess ? bankedRam : TGT_ROM;
    else if (strobes.bankHigh) tgt = strobes.ramAccess ? plainRam : TGT_ROM;

    memSel    = tgt;
    ioSel     = strobes.ioPage;
    wrInhibit = strobes.blockWrite;
    physAddr  = cpuAddr;
  end

  always_comb begin
    if (!$isunknown({cpuAddr, cpuWrite, hiRdEn, hiWrEn, bankTwo, altZp})) begin
      p_io_no_target_r3: assert (!ioSel || memSel == 3'd0)
        else $error("I/O page carries a memory target");
      p_stack_aux_r1: assert (!(strobes.zeroStack && altZp) || memSel == 3'd2)
        else $error("stack pages not in auxiliary RAM");
      p_rom_read_r5: assert (!((strobes.bankLow || strobes.bankHigh) && !cpuWrite && !hiRdEn)
                             || memSel == 3'd0)
        else $error("high read not from ROM");
      p_bank_write_r9: assert (!(strobes.bankLow && cpuWrite && hiWrEn)
                               || (memSel >= 3'd3 && memSel <= 3'd6 && !wrInhibit))
        else $error("enabled banked write misrouted");
      p_inhibit_read_r11: assert (cpuWrite || !wrInhibit)
        else $error("inhibit on a read");
    end
  end

endmodule

// File: rtl/bankMapper.sv
module bankMapper
  import bank_map_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int PAGE_W     = 8,
  parameter int STACK_END  = 8'h01,
  parameter int IO_PAGE    = 8'hC0,
  parameter int ROMWIN_END = 8'hCF,
  parameter int BANK_START = 8'hD0,
  parameter int BANK_SPLIT = 8'hE0
) (
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic              cpuWrite,
  input  logic              hiRdEn,
  input  logic              hiWrEn,
  input  logic              bankTwo,
  input  logic              altZp,
  output logic [2:0]        memSel,
  output logic              ioSel,
  output logic              wrInhibit,
  output logic [ADDR_W-1:0] physAddr
);

  localparam int PageLsb = ADDR_W - PAGE_W;

  map_strobe_t strobes;

  mapCtrl #(
    .PAGE_W(PAGE_W), .STACK_END(STACK_END), .IO_PAGE(IO_PAGE),
    .ROMWIN_END(ROMWIN_END), .BANK_START(BANK_START), .BANK_SPLIT(BANK_SPLIT)
  ) i_ctrl (
    .page     (cpuAddr[ADDR_W-1:PageLsb]),
    .cpuWrite (cpuWrite),
    .hiRdEn   (hiRdEn),
    .hiWrEn   (hiWrEn),
    .strobes  (strobes)
  );

  mapDatapath #(.ADDR_W(ADDR_W)) i_dp (
    .cpuAddr   (cpuAddr),
    .strobes   (strobes),
    .cpuWrite  (cpuWrite),
    .hiRdEn    (hiRdEn),
    .hiWrEn    (hiWrEn),
    .bankTwo   (bankTwo),
    .altZp     (altZp),
    .memSel    (memSel),
    .ioSel     (ioSel),
    .wrInhibit (wrInhibit),
    .physAddr  (physAddr)
  );

endmodule

// File: tb/test_bankMapper.sv
module test_bankMapper;

  logic        clk = 1'b0;
  logic [15:0] cpuAddr = '0;
  logic        cpuWrite = 1'b0, hiRdEn = 1'b0, hiWrEn = 1'b0, bankTwo = 1'b0, altZp = 1'b0;
  logic [2:0]  memSel;
  logic        ioSel, wrInhibit;
  logic [15:0] physAddr;
  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  bankMapper i_bankMapper (.*);

  // addr[25:10] flags{wr,rd,we,bk,az}[9:5] sel[4:2] io[1] inh[0]
  localparam int NV = 15;
  localparam logic [25:0] VEC [NV] = '{
    {16'h0000, 5'b00000, 3'd1, 1'b0, 1'b0},  // R1
    {16'h01FF, 5'b10001, 3'd2, 1'b0, 1'b0},  // R1
    {16'h4000, 5'b11111, 3'd1, 1'b0, 1'b0},  // R2
    {16'hC030, 5'b01111, 3'd0, 1'b1, 1'b0},  // R3
    {16'hC600, 5'b11100, 3'd0, 1'b0, 1'b1},  // R4
    {16'hC600, 5'b01100, 3'd0, 1'b0, 1'b0},  // R4
    {16'hD123, 5'b01000, 3'd3, 1'b0, 1'b0},  // R6
    {16'hD800, 5'b01011, 3'd6, 1'b0, 1'b0},  // R6
    {16'hDFFF, 5'b01001, 3'd5, 1'b0, 1'b0},  // R6
    {16'hE000, 5'b01010, 3'd1, 1'b0, 1'b0},  // R7
    {16'hFFFC, 5'b01011, 3'd2, 1'b0, 1'b0},  // R7
    {16'hF000, 5'b00011, 3'd0, 1'b0, 1'b0},  // R5
    {16'hD000, 5'b11000, 3'd3, 1'b0, 1'b1},  // R8
    {16'hD400, 5'b10110, 3'd4, 1'b0, 1'b0},  // R9
    {16'hE800, 5'b10101, 3'd2, 1'b0, 1'b0}   // R9
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h (addr %h)", tag, act, exp, cpuAddr);
    end
  endtask

  // expected result from the requirement list
  function automatic logic [4:0] model(input logic [15:0] a, input logic [4:0] f);
    logic wr, rd, we, bk, az;
    logic [7:0] pg;
    logic [2:0] s;
    logic io, inh, ram;
    {wr, rd, we, bk, az} = f;
    pg = a[15:8];
    s = 3'd0; io = 1'b0; inh = 1'b0;
    ram = rd || (wr && we);
    if (pg <= 8'h01)      s = az ? 3'd2 : 3'd1;
    else if (pg < 8'hC0)  s = 3'd1;
    else if (pg == 8'hC0) io = 1'b1;
    else if (pg <= 8'hCF) inh = wr;
    else begin
      inh = wr && !we;
      if (ram) begin
        if (pg < 8'hE0) s = 3'd3 + {1'b0, az, 1'b0} + {2'b0, bk};
        else            s = az ? 3'd2 : 3'd1;
      end
    end
    return {s, io, inh};
  endfunction

  task automatic apply(input logic [15:0] a, input logic [4:0] f);
    @(negedge clk);
    cpuAddr = a;
    {cpuWrite, hiRdEn, hiWrEn, bankTwo, altZp} = f;
    #5;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    // idle state after start: address 0, all flags clear
    apply(16'h0000, 5'b00000);
    check(memSel == 3'd1 && !ioSel && !wrInhibit, "R1 idle", memSel, 1);

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][25:10], VEC[i][9:5]);
      check(memSel == VEC[i][4:2], "R1-vector sel", memSel, VEC[i][4:2]);
      check(ioSel == VEC[i][1], "R3 vector io", ioSel, VEC[i][1]);
      check(wrInhibit == VEC[i][0], "R8 vector inhibit", wrInhibit, VEC[i][0]);
      check(physAddr == VEC[i][25:10], "R10 offset", physAddr, VEC[i][25:10]);
    end

    // boundary sweep: every flag combination on pages next to each edge
    begin
      logic [7:0] pages [12] = '{8'h00, 8'h01, 8'h02, 8'hBF, 8'hC0, 8'hC1,
                                 8'hCF, 8'hD0, 8'hDF, 8'hE0, 8'hEF, 8'hFF};
      for (int p = 0; p < 12; p++) begin
        for (int f = 0; f < 32; f++) begin
          logic [4:0] e;
          logic [15:0] a;
          a = {pages[p], 8'(p * 17 + f)};
          e = model(a, 5'(f));
          apply(a, 5'(f));
          check(memSel == e[4:2], "R6 R7 sweep sel", memSel, e[4:2]);
          check(ioSel == e[1], "R3 sweep io", ioSel, e[1]);
          check(wrInhibit == e[0], "R4 R8 R11 sweep inhibit", wrInhibit, e[0]);
          check(physAddr == a, "R10 sweep offset", physAddr, a);
        end
      end
    end

    // R7: bankTwo toggled on upper region has no effect
    apply(16'hF123, 5'b01000);
    check(memSel == 3'd1, "R7 bank0", memSel, 1);
    apply(16'hF123, 5'b01010);
    check(memSel == 3'd1, "R7 bank1 ignored", memSel, 1);
    // R9: enabled write with read disabled still goes to RAM
    apply(16'hDABC, 5'b10111);
    check(memSel == 3'd6 && !wrInhibit, "R9 write rd off", memSel, 6);
    // R2: flags have no effect on plain low RAM
    apply(16'hBFFF, 5'b11111);
    check(memSel == 3'd1 && !wrInhibit, "R2 top of low RAM", memSel, 1);
    // R4: protected window write even with write enable
    apply(16'hCFFF, 5'b11111);
    check(wrInhibit == 1'b1, "R4 window edge", wrInhibit, 1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule